// File: doc/BRIEF.md
# Four-Channel Strobed Input Glitch Filter

This block cleans up four timer capture inputs, A to D, before they reach downstream capture and edge logic. Each input has its own enable. With the enable off, the input appears on the output unchanged and combinationally. With the enable on, the input is resynchronized to the base clock and sampled on a strobe. The filtered output moves to a new level only after three consecutive samples agree on that level.

The sampling strobe comes from a single source shared by all four channels. A 2-bit select chooses between every base clock, the base clock divided by 8, the base clock divided by 32, or rising edges of an external count clock. The divided strobes come from one free-running prescaler.

An 8-bit control register sits on a simple write/read port and holds the four enables and the strobe select. A per-instance parameter can reserve the enable of channel C, or the enables of both C and D, for instances that lack those inputs.

Top module: `nf_input_filter`

## Requirements
- R1: While reset is high and after it is released, the control register reads 0x00, and every output equals its input pin.
- R2: A write stores bits 0 to 3 as the enables of channels A, B, C, D (bit 0 is A) and bits 5:4 as the strobe select; the stored value reads back on the next cycle.
- R3: Bits 7:6 of the register always read 0, and writing them has no effect.
- R4: With RSV_MODE=1 the channel C enable (bit 2) is reserved; with RSV_MODE=2 the C and D enables (bits 3:2) are reserved. A reserved enable reads 0, ignores writes, and its channel passes its pin straight through.
- R5: A channel whose enable is 0 drives its output equal to its input pin in the same cycle, without a register.
- R6: An enabled channel changes its output only when three consecutive strobed samples agree on the new level; a pulse shorter than three samples never reaches the output.
- R7: Select 00 takes a sample on every base clock cycle.
- R8: Select 01 takes a sample once every 8 base clocks, when the 5-bit prescaler (cleared by reset, counting up each cycle) has its low three bits all ones.
- R9: Select 10 takes a sample once every 32 base clocks, when the prescaler equals 31.
- R10: Select 11 takes a sample in the cycle after each rising edge of the external clock is seen at the output of its two-flop synchronizer.
- R11: Each input passes two synchronizer flops before sampling, so with select 00 a clean level change reaches the output on the fifth rising clock edge after the input changes.
- R12: On reset, and whenever a channel is disabled, its output and sample history track the synchronized pin, so enabling a channel on a steady input produces no output change.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Base clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Control register write strobe |
| wr_data | input | 8 | Control register write value |
| rd_data | output | 8 | Control register read value |
| ext_clk | input | 1 | External count clock, asynchronous |
| pin_in | input | 4 | Raw capture inputs, bit 0 is channel A |
| filt_out | output | 4 | Filtered levels, bit 0 is channel A |

## Verification
The bench builds two instances on the same stimulus: u0 with RSV_MODE=0, so all four enables exist and the full filter path is compared cycle by cycle against a bench model under each strobe select, and u1 with RSV_MODE=2, which brings within reach the reserved C and D enables that must read 0 and keep those channels in pass-through even when written with ones. Random pin patterns with random hold lengths cover agreement and rejection under every select, while directed cases pin down the five-edge latency, a two-cycle glitch and a glitch-free enable.

// File: rtl/nf_pkg.sv
package nf_pkg;

    localparam int NUM_CH   = 4;
    localparam int CTRL_W   = 8;
    localparam int HIST_LEN = 3;
    localparam int SYNC_LEN = 2;

    typedef enum logic [1:0] {
        SRC_BASE  = 2'b00,
        SRC_DIV8  = 2'b01,
        SRC_DIV32 = 2'b10,
        SRC_EXT   = 2'b11
    } smp_src_e;

    typedef struct packed {
        logic [1:0]        rsvd;
        smp_src_e          src;
        logic [NUM_CH-1:0] en;
    } ctrl_t;

    // Writable bits: select plus the enables that exist in this instance.
    function automatic logic [CTRL_W-1:0] write_mask(int rsv_mode);
        logic [CTRL_W-1:0] m;
        m = 8'h3F;
        if (rsv_mode >= 1) m[2] = 1'b0;
        if (rsv_mode >= 2) m[3] = 1'b0;
        return m;
    endfunction

    function automatic logic agree(logic [HIST_LEN-1:0] h);
        return (h == '0) || (h == '1);
    endfunction

endpackage

// File: rtl/nf_ctrl_reg.sv
module nf_ctrl_reg
    import nf_pkg::*;
#(
    parameter int RSV_MODE = 0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [CTRL_W-1:0] wr_data,
    output logic [CTRL_W-1:0] rd_data,
    output logic [NUM_CH-1:0] en,
    output smp_src_e          src
);
    localparam logic [CTRL_W-1:0] WMASK = write_mask(RSV_MODE);

    ctrl_t ctrl_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= '0;
        end else if (wr_en) begin
            ctrl_q <= ctrl_t'(wr_data & WMASK);
        end
    end

    assign rd_data = ctrl_q;
    assign en      = ctrl_q.en;
    assign src     = ctrl_q.src;

    // R2
    wr_readback_chk: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> (rd_data == ($past(wr_data) & WMASK)));

    // R4
    rsv_zero_chk: assert property (@(posedge clk) disable iff (rst)
        ((rd_data & ~WMASK) == '0));

endmodule

// File: rtl/nf_strobe_gen.sv
module nf_strobe_gen
    import nf_pkg::*;
#(
    parameter int DIV_A = 8,
    parameter int DIV_B = 32
) (
    input  logic     clk,
    input  logic     rst,
    input  smp_src_e src,
    input  logic     ext_clk,
    output logic     strobe
);
    localparam int LOG_A = $clog2(DIV_A);
    localparam int LOG_B = $clog2(DIV_B);

    logic [LOG_B-1:0] pre_q;
    logic [2:0]       ext_q;
    logic             tick_a;
    logic             tick_b;
    logic             tick_ext;

    always_ff @(posedge clk) begin
        if (rst) begin
            pre_q <= '0;
            ext_q <= '0;
        end else begin
            pre_q <= pre_q + 1'b1;
            ext_q <= {ext_q[1:0], ext_clk};
        end
    end

    assign tick_a   = (pre_q[LOG_A-1:0] == {LOG_A{1'b1}});
    assign tick_b   = (pre_q == {LOG_B{1'b1}});
    assign tick_ext = ext_q[1] & ~ext_q[2];

    always_comb begin
        unique case (src)
            SRC_BASE:  strobe = 1'b1;
            SRC_DIV8:  strobe = tick_a;
            SRC_DIV32: strobe = tick_b;
            SRC_EXT:   strobe = tick_ext;
            default:   strobe = 1'b1;
        endcase
    end

    // R8
    div8_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        tick_a |=> !tick_a);

    // R9
    div32_nested_chk: assert property (@(posedge clk) disable iff (rst)
        tick_b |-> tick_a);

    // R10
    ext_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        tick_ext |=> !tick_ext);

endmodule

// File: rtl/nf_channel.sv
module nf_channel
    import nf_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic en,
    input  logic strobe,
    input  logic pin,
    output logic out
);
    logic [SYNC_LEN-1:0] sync_q;
    logic [HIST_LEN-1:0] hist_q;
    logic [HIST_LEN-1:0] hist_nx;
    logic                lvl_q;
    logic                s_lvl;

    always_ff @(posedge clk) begin
        sync_q <= {sync_q[SYNC_LEN-2:0], pin};
    end

    assign s_lvl   = sync_q[SYNC_LEN-1];
    assign hist_nx = {hist_q[HIST_LEN-2:0], s_lvl};

    always_ff @(posedge clk) begin
        if (rst || !en) begin
            hist_q <= {HIST_LEN{s_lvl}};
            lvl_q  <= s_lvl;
        end else if (strobe) begin
            hist_q <= hist_nx;
            if (agree(hist_nx)) begin
                lvl_q <= hist_nx[0];
            end
        end
    end

    assign out = en ? lvl_q : pin;

    // R6
    change_on_strobe_chk: assert property (@(posedge clk) disable iff (rst)
        (en && $past(en) && (lvl_q != $past(lvl_q))) |-> $past(strobe));

    // R6
    change_agreed_chk: assert property (@(posedge clk) disable iff (rst)
        (en && $past(en) && (lvl_q != $past(lvl_q))) |-> (hist_q == {HIST_LEN{lvl_q}}));

    // R12
    idle_track_chk: assert property (@(posedge clk) disable iff (rst)
        (!$past(en) && !$past(rst)) |-> (lvl_q == $past(s_lvl)));

endmodule

// File: rtl/nf_input_filter.sv
module nf_input_filter
    import nf_pkg::*;
#(
    parameter int RSV_MODE = 0,
    parameter int DIV_A    = 8,
    parameter int DIV_B    = 32
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        wr_en,
    input  logic [7:0]  wr_data,
    output logic [7:0]  rd_data,
    input  logic        ext_clk,
    input  logic [3:0]  pin_in,
    output logic [3:0]  filt_out
);
    logic [NUM_CH-1:0] en;
    smp_src_e          src;
    logic              strobe;

    nf_ctrl_reg #(.RSV_MODE(RSV_MODE)) u_reg (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .wr_data (wr_data),
        .rd_data (rd_data),
        .en      (en),
        .src     (src)
    );

    nf_strobe_gen #(.DIV_A(DIV_A), .DIV_B(DIV_B)) u_stb (
        .clk     (clk),
        .rst     (rst),
        .src     (src),
        .ext_clk (ext_clk),
        .strobe  (strobe)
    );

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        nf_channel u_ch (
            .clk    (clk),
            .rst    (rst),
            .en     (en[c]),
            .strobe (strobe),
            .pin    (pin_in[c]),
            .out    (filt_out[c])
        );
    end

endmodule

// File: tb/sim_nf_input_filter.sv
module sim_nf_input_filter;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic       ext_clk = 1'b0;
    logic [3:0] pin_in = 4'h0;
    logic [7:0] rd0, rd1;
    logic [3:0] out0, out1;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;
    bit cmp_on = 1'b0;
    string cur_req = "R7";

    always #5 clk = ~clk;

    nf_input_filter #(.RSV_MODE(0)) u0 (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd0),
        .ext_clk(ext_clk), .pin_in(pin_in), .filt_out(out0));

    nf_input_filter #(.RSV_MODE(2)) u1 (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd1),
        .ext_clk(ext_clk), .pin_in(pin_in), .filt_out(out1));

    // Bench model of u0 built from the requirements.
    logic [7:0] m_reg;
    logic [3:0] m_s1, m_s2;
    logic [4:0] m_pre;
    logic [2:0] m_ext;
    logic [2:0] m_hist [4];
    logic [3:0] m_q;

    function automatic logic model_strobe(logic [1:0] sel, logic [4:0] pre, logic [2:0] e);
        case (sel)
            2'b00:   return 1'b1;
            2'b01:   return pre[2:0] == 3'b111;
            2'b10:   return pre == 5'd31;
            default: return e[1] && !e[2];
        endcase
    endfunction

    function automatic logic [3:0] model_out(logic [7:0] r, logic [3:0] q, logic [3:0] p);
        return (r[3:0] & q) | (~r[3:0] & p);
    endfunction

    always @(posedge clk) begin
        logic stb;
        logic [2:0] nh;
        m_s1 <= pin_in;
        m_s2 <= m_s1;
        stb = model_strobe(m_reg[5:4], m_pre, m_ext);
        for (int c = 0; c < 4; c++) begin
            if (rst || !m_reg[c]) begin
                m_hist[c] <= {3{m_s2[c]}};
                m_q[c]    <= m_s2[c];
            end else if (stb) begin
                nh = {m_hist[c][1:0], m_s2[c]};
                m_hist[c] <= nh;
                if (nh == 3'b000 || nh == 3'b111) m_q[c] <= nh[0];
            end
        end
        if (rst) begin
            m_reg <= 8'h00;
            m_pre <= 5'd0;
            m_ext <= 3'd0;
        end else begin
            if (wr_en) m_reg <= wr_data & 8'h3F;
            m_pre <= m_pre + 5'd1;
            m_ext <= {m_ext[1:0], ext_clk};
        end
    end

    task automatic check(string req, logic [7:0] act, logic [7:0] exp, string what);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    always @(negedge clk) begin
        #2;
        if (cmp_on) begin
            check(cur_req, {4'h0, out0}, {4'h0, model_out(m_reg, m_q, pin_in)}, "u0 outputs vs model");
        end
    end

    task automatic write_reg(logic [7:0] v);
        @(negedge clk);
        wr_en = 1'b1;
        wr_data = v;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic settle(logic [3:0] p, int n);
        @(negedge clk);
        pin_in = p;
        repeat (n) @(negedge clk);
    endtask

    task automatic random_phase(logic [1:0] sel, string req, int cycles);
        int hold;
        cur_req = req;
        write_reg({2'b00, sel, 4'hF});
        cmp_on = 1'b1;
        for (int i = 0; i < cycles; i++) begin
            @(negedge clk);
            for (int c = 0; c < 4; c++) begin
                hold = (sel == 2'b00) ? 4 : (sel == 2'b11 ? 10 : 40);
                if ($urandom_range(hold, 0) == 0) pin_in[c] = ~pin_in[c];
            end
            if ($urandom_range(3, 0) == 0) ext_clk = ~ext_clk;
        end
        cmp_on = 1'b0;
    endtask

    initial begin
        void'($urandom(32'd4711));
        pin_in = 4'b1010;
        repeat (5) @(negedge clk);
        #2;
        // R1: during reset
        check("R1", rd0, 8'h00, "reg in reset");
        check("R1", {4'h0, out0}, {4'h0, pin_in}, "outputs follow pins in reset");
        rst = 1'b0;
        @(negedge clk); #2;
        check("R1", rd0, 8'h00, "reg after reset");
        check("R1", {4'h0, out1}, {4'h0, pin_in}, "u1 outputs after reset");

        // R5: disabled channels are combinational pass-through
        for (int i = 0; i < 6; i++) begin
            @(negedge clk);
            pin_in = 4'($urandom_range(15, 0));
            #1;
            check("R5", {4'h0, out0}, {4'h0, pin_in}, "disabled pass-through");
        end

        // R2, R3: readback and reserved top bits
        write_reg(8'hFF); #2;
        check("R3", rd0, 8'h3F, "top bits read zero");
        write_reg(8'hC5); #2;
        check("R2", rd0, 8'h05, "enables and select readback");
        write_reg(8'h2A); #2;
        check("R2", rd0, 8'h2A, "select 10 with B, D");

        // R4: u1 reserves C and D
        write_reg(8'hFF); #2;
        check("R4", rd1, 8'h33, "u1 reserved enables read zero");
        @(negedge clk);
        pin_in[3:2] = ~pin_in[3:2];
        #1;
        check("R4", {6'h0, out1[3:2]}, {6'h0, pin_in[3:2]}, "u1 C,D pass-through");

        // R11, R6: latency of a clean edge under select 00
        write_reg(8'h00);
        settle(4'h0, 6);
        write_reg(8'h0F);
        repeat (2) @(negedge clk);
        pin_in = 4'hF;
        repeat (4) @(negedge clk);
        #2;
        check("R11", {4'h0, out0}, 8'h00, "no change after four edges");
        @(negedge clk); #2;
        check("R11", {4'h0, out0}, 8'h0F, "change on fifth edge");

        // R6: a two-cycle glitch is rejected
        repeat (4) @(negedge clk);
        pin_in = 4'h0;
        repeat (2) @(negedge clk);
        pin_in = 4'hF;
        repeat (8) @(negedge clk);
        #2;
        check("R6", {4'h0, out0}, 8'h0F, "two-cycle glitch rejected");

        // R12: enabling on a steady high input gives no change
        write_reg(8'h00);
        settle(4'hF, 6);
        @(negedge clk);
        wr_en = 1'b1;
        wr_data = 8'h0F;
        for (int i = 0; i < 6; i++) begin
            @(negedge clk);
            wr_en = 1'b0;
            #2;
            check("R12", {4'h0, out0}, 8'h0F, "enable on steady input");
        end
        pin_in = 4'h0;
        repeat (2) @(negedge clk);
        pin_in = 4'hF;
        repeat (6) @(negedge clk);
        #2;
        check("R12", {4'h0, out0}, 8'h0F, "history loaded with pin level");

        // R7..R10: random stimulus per select against the model
        random_phase(2'b00, "R7", 600);
        random_phase(2'b01, "R8", 1500);
        random_phase(2'b10, "R9", 4000);
        random_phase(2'b11, "R10", 1500);

        // R4 under random: u1 C,D stay pass-through
        write_reg(8'hFF);
        for (int i = 0; i < 20; i++) begin
            @(negedge clk);
            pin_in = 4'($urandom_range(15, 0));
            #1;
            check("R4", {6'h0, out1[3:2]}, {6'h0, pin_in[3:2]}, "u1 reserved channels");
        end

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
            $finish;
        end
    end

endmodule